// File: doc/BRIEF.md
# Pixel Invert and Mirror Engine

This block processes a 16 by 16 image of 8-bit pixels kept in an external memory. After a start pulse it visits every source pixel once, from address 0 up to the last address. It reads the pixel and writes a result into a separate destination image. The selected operation is one of these: complement the pixel at the same position, mirror the image top to bottom, mirror it left to right, or copy it unchanged. A bank output selects the destination image during writes, so the source image is never overwritten while a mirror is in progress.

The engine drives an address bus, a write-data bus, active-low read and write strobes, and a direction line. It receives read data on its own input bus. Each pixel takes a fixed seven-cycle strobe sequence. A one-cycle done pulse marks the end of a pass. The row and column widths are parameters. The address is the row index in the upper bits followed by the column index in the lower bits.

Top module: `pix_xform_engine`

## Requirements
- R1: While reset is held and after reset is released, the outputs are: oe_no and we_no high, rw_o, bank_o and done_o low.
- R2: A start_i pulse while idle begins a pass and captures func_i. Each pixel then takes seven cycles, with oe_no levels 1,0,0,1,1,1,1 and we_no levels 1,1,1,1,1,0,1.
- R3: In the first four cycles of a pixel, rw_o and bank_o are low and addr_o is the source address. The pixel is captured from data_i at the end of the second cycle in which oe_no is low.
- R4: In the last three cycles of a pixel, rw_o and bank_o are high and oe_no stays high. we_no is low for exactly one cycle, and addr_o and data_o do not change between that cycle and the next.
- R5: func 2'b00 writes the bitwise complement of the pixel to the same address (for example 8'd128 becomes 8'd127).
- R6: func 2'b01 writes the pixel unchanged to the address with the row field (bits [7:4]) complemented, so 8'h01 goes to 8'hF1.
- R7: func 2'b10 writes the pixel unchanged to the address with the column field (bits [3:0]) complemented, so 8'h00 goes to 8'h0F.
- R8: func 2'b11 writes the pixel unchanged to the same address.
- R9: The source address starts at 0 and goes up by one after each pixel is written, so all 256 pixels are visited in ascending order.
- R10: done_o is high for exactly one cycle. That cycle follows the cycle in which we_no returns high for source address 8'hFF. The engine is idle in the next cycle.
- R11: start_i and func_i have no effect during a pass or during the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a pass when the engine is idle |
| func_i | input | 2 | Operation select: 00 complement, 01 mirror rows, 10 mirror columns, 11 copy |
| addr_o | output | 8 | Memory address, with the row in the upper bits and the column in the lower bits |
| data_i | input | 8 | Read data from memory |
| data_o | output | 8 | Write data to memory |
| oe_no | output | 1 | Read strobe, active low |
| we_no | output | 1 | Write strobe, active low |
| rw_o | output | 1 | High during the write part of each pixel |
| bank_o | output | 1 | Image select: 0 for the source image, 1 for the destination image |
| done_o | output | 1 | One-cycle end-of-pass pulse |

## Verification
The bench builds the engine with its default 4-bit row and 4-bit column fields. This makes the full 256-pixel pass reachable, including the last address 8'hFF and the done pulse that follows it. All four operations run over a source pattern in which no two neighbouring values are equal, and address 0 holds 128. The bench then compares the whole destination image, and also checks that the source image is intact. In each pass, start_i and func_i are toggled once during the pass and once during the done cycle.

// File: rtl/pxe_pkg.sv
package pxe_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RADDR, ST_OE_LO, ST_LATCH, ST_OE_HI,
    ST_WADDR, ST_WE_LO, ST_WE_HI, ST_DONE
  } pxe_state_e;

  typedef enum logic [1:0] {
    FN_INV   = 2'b00,
    FN_VFLIP = 2'b01,
    FN_HFLIP = 2'b10,
    FN_COPY  = 2'b11
  } pxe_func_e;
endpackage

// File: rtl/pxe_seq_ctrl.sv
module pxe_seq_ctrl
  import pxe_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic last_i,
  output logic clr_o,
  output logic cap_o,
  output logic step_o,
  output logic wr_sel_o,
  output logic oe_no,
  output logic we_no,
  output logic rw_o,
  output logic bank_o,
  output logic done_o
);
  pxe_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_RADDR;
      ST_RADDR: state_d = ST_OE_LO;
      ST_OE_LO: state_d = ST_LATCH;
      ST_LATCH: state_d = ST_OE_HI;
      ST_OE_HI: state_d = ST_WADDR;
      ST_WADDR: state_d = ST_WE_LO;
      ST_WE_LO: state_d = ST_WE_HI;
      ST_WE_HI: state_d = last_i ? ST_DONE : ST_RADDR;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign clr_o    = (state_q == ST_IDLE) && start_i;
  assign cap_o    = (state_q == ST_LATCH);
  assign step_o   = (state_q == ST_WE_HI);
  assign wr_sel_o = (state_q == ST_WADDR) || (state_q == ST_WE_LO) || (state_q == ST_WE_HI);
  assign oe_no    = !((state_q == ST_OE_LO) || (state_q == ST_LATCH));
  assign we_no    = (state_q != ST_WE_LO);
  assign rw_o     = wr_sel_o;
  assign bank_o   = wr_sel_o;
  assign done_o   = (state_q == ST_DONE);

  // strobes never overlap; a write always runs with OE and RW high
  p_write_ctrl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> (oe_no && rw_o && bank_o));
  p_read_ctrl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_no |-> (!rw_o && !bank_o && we_no));
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && state_q == ST_IDLE));
  p_busy_no_restart_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OE_HI) |=> (state_q == ST_WADDR));
endmodule

// File: rtl/pxe_addr_gen.sv
module pxe_addr_gen #(
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 4,
  localparam int AW = ROW_BITS + COL_BITS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic          wr_sel_i,
  input  logic          row_flip_i,
  input  logic          col_flip_i,
  output logic [AW-1:0] addr_o,
  output logic          last_i_o
);
  localparam logic [AW-1:0] ROW_MASK = {{ROW_BITS{1'b1}}, {COL_BITS{1'b0}}};
  localparam logic [AW-1:0] COL_MASK = {{ROW_BITS{1'b0}}, {COL_BITS{1'b1}}};

  logic [AW-1:0] src_q, dst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     src_q <= '0;
    else if (clr_i)  src_q <= '0;
    else if (step_i) src_q <= src_q + 1'b1;
  end

  assign dst      = src_q ^ (row_flip_i ? ROW_MASK : '0) ^ (col_flip_i ? COL_MASK : '0);
  assign addr_o   = wr_sel_i ? dst : src_q;
  assign last_i_o = &src_q;
endmodule

// File: rtl/pxe_data_path.sv
module pxe_data_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              invert_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] pix_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pix_q <= '0;
    else if (cap_i) pix_q <= data_i;
  end

  assign data_o = invert_i ? ~pix_q : pix_q;
endmodule

// File: rtl/pix_xform_engine.sv
module pix_xform_engine
  import pxe_pkg::*;
#(
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 4,
  parameter int DATA_W   = 8,
  localparam int AW = ROW_BITS + COL_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        func_i,
  output logic [AW-1:0]     addr_o,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              oe_no,
  output logic              we_no,
  output logic              rw_o,
  output logic              bank_o,
  output logic              done_o
);
  pxe_func_e func_q;
  logic clr, cap, step, wr_sel, last;

  // operation is frozen for the whole pass
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   func_q <= FN_INV;
    else if (clr)  func_q <= pxe_func_e'(func_i);
  end

  pxe_seq_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .last_i   (last),
    .clr_o    (clr),
    .cap_o    (cap),
    .step_o   (step),
    .wr_sel_o (wr_sel),
    .oe_no    (oe_no),
    .we_no    (we_no),
    .rw_o     (rw_o),
    .bank_o   (bank_o),
    .done_o   (done_o)
  );

  pxe_addr_gen #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .step_i     (step),
    .wr_sel_i   (wr_sel),
    .row_flip_i (func_q == FN_VFLIP),
    .col_flip_i (func_q == FN_HFLIP),
    .addr_o     (addr_o),
    .last_i_o   (last)
  );

  pxe_data_path #(.DATA_W(DATA_W)) u_data (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_i    (cap),
    .invert_i (func_q == FN_INV),
    .data_i   (data_i),
    .data_o   (data_o)
  );

  // address and data held across the write strobe
  p_we_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |=> (we_no && $stable(addr_o) && $stable(data_o)));
  p_last_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && last) |=> done_o);
  p_func_frozen_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_no |=> $stable(func_q));
endmodule

// File: tb/pix_xform_engine_tb.sv
module pix_xform_engine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] func = 2'b00;
  logic [7:0] addr, din, dout;
  logic oe_n, we_n, rw, bank, done;

  int errors = 0;
  int checks = 0;
  logic [7:0] mem [0:1][0:255];

  always #4 clk = ~clk;

  pix_xform_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .func_i(func),
    .addr_o(addr), .data_i(din), .data_o(dout), .oe_no(oe_n),
    .we_no(we_n), .rw_o(rw), .bank_o(bank), .done_o(done)
  );

  assign din = oe_n ? 8'hA5 : mem[bank][addr];

  function automatic int exp_dst(int f, int a);
    case (f)
      1: return a ^ 8'hF0;
      2: return a ^ 8'h0F;
      default: return a;
    endcase
  endfunction

  function automatic int exp_val(int f, int v);
    return (f == 0) ? ((~v) & 8'hFF) : v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference: busy flag, phase 0..6, pixel index
  int m_busy = 0, m_phase = 0, m_pix = 0, m_done = 0, m_func = 0;
  bit cmp_en = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_phase = 0; m_pix = 0; m_done = 0;
    end else if (m_done != 0) begin
      m_done = 0;
    end else if (m_busy == 0) begin
      if (start) begin
        m_busy = 1; m_phase = 0; m_pix = 0; m_func = int'(func);
      end
    end else if (m_phase == 6) begin
      if (m_pix == 255) begin
        m_busy = 0; m_done = 1;
      end else begin
        m_pix++; m_phase = 0;
      end
    end else begin
      m_phase++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      int e_oe, e_we, e_wr;
      e_oe = (m_busy != 0 && (m_phase == 1 || m_phase == 2)) ? 0 : 1;
      e_we = (m_busy != 0 && m_phase == 5) ? 0 : 1;
      e_wr = (m_busy != 0 && m_phase >= 4) ? 1 : 0;
      chk(oe_n == e_oe[0], "R2 oe_no", oe_n, e_oe);
      chk(we_n == e_we[0], "R4 we_no", we_n, e_we);
      chk(rw == e_wr[0], "R3 rw_o", rw, e_wr);
      chk(bank == e_wr[0], "R4 bank_o", bank, e_wr);
      chk(done == (m_done != 0), "R10 done_o", done, m_done);
      if (m_busy != 0 && m_phase < 4)
        chk(addr == m_pix[7:0], "R9 source addr", addr, m_pix);
      if (m_busy != 0 && m_phase >= 4) begin
        int ea, ev;
        ea = exp_dst(m_func, m_pix);
        ev = exp_val(m_func, int'(mem[0][m_pix]));
        chk(addr == ea[7:0], "R5/R6/R7/R8 dest addr", addr, ea);
        chk(dout == ev[7:0], "R3/R5 write data", dout, ev);
      end
      if (!we_n) mem[bank][addr] = dout;
    end
  end

  task automatic run_pass(input int f);
    int cnt;
    for (int i = 0; i < 256; i++) mem[1][i] = 8'h5A;
    @(negedge clk);
    start = 1'b1; func = f[1:0];
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!done) begin
      @(negedge clk);
      cnt++;
      // R11: restart and function change mid-pass are ignored
      if (cnt == 300) begin start = 1'b1; func = ~f[1:0]; end
      if (cnt == 301) begin start = 1'b0; func = f[1:0]; end
    end
    // R11: start during the done cycle is ignored
    start = 1'b1; func = ~f[1:0];
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(oe_n && we_n && !done, "R11 idle after done", {oe_n, we_n, done}, 3'b110);
      @(negedge clk);
    end
    begin
      int bad_dst, bad_src;
      bad_dst = 0; bad_src = 0;
      for (int i = 0; i < 256; i++) begin
        int ev;
        ev = exp_val(f, int'(mem[0][i]));
        if (int'(mem[1][exp_dst(f, i)]) != ev) bad_dst++;
        if (int'(mem[0][i]) != ((i * 37 + 11) & 8'hFF) && i != 0) bad_src++;
      end
      chk(bad_dst == 0, f == 0 ? "R5 image" : f == 1 ? "R6 image" : f == 2 ? "R7 image" : "R8 image",
          bad_dst, 0);
      chk(bad_src == 0 && mem[0][0] == 8'd128, "R9 source intact", bad_src, 0);
    end
    if (f == 0) chk(mem[1][0] == 8'd127, "R5 128 to 127", mem[1][0], 127);
    if (f == 1) chk(mem[1][8'hF1] == mem[0][8'h01], "R6 01 to F1", mem[1][8'hF1], mem[0][8'h01]);
    if (f == 2) chk(mem[1][8'h0F] == mem[0][8'h00], "R7 00 to 0F", mem[1][8'h0F], mem[0][8'h00]);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[0][i] = 8'((i * 37 + 11) & 8'hFF);
      mem[1][i] = 8'h00;
    end
    mem[0][0] = 8'd128;
    repeat (3) @(negedge clk);
    chk(oe_n && we_n && !rw && !bank && !done, "R1 in reset", {oe_n, we_n, rw, bank, done}, 5'b11000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(oe_n && we_n && !rw && !bank && !done, "R1 after reset", {oe_n, we_n, rw, bank, done}, 5'b11000);
    cmp_en = 1'b1;
    run_pass(0);
    run_pass(1);
    run_pass(2);
    run_pass(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule